// File: doc/BRIEF.md
# Eight-Pin Bidirectional Port with Pullup Control

This block is a general-purpose port of eight pins. Software sets each pin's direction and drive value through two writable registers on a small request/acknowledge register bus. For every pin the block produces a drive value, an output enable and a weak-pullup enable for an external pad. When a pin is an output it drives its bit of the output register. When a pin is an input, the same output-register bit chooses between a weak pullup and a fully floating pin. Pin levels come back through a two-flop synchronizer into a read-only input register.

Two resets are provided. The system reset clears both writable registers. The power-fail reset only returns the bus sequencer and the synchronizer to their idle state, and leaves the direction and output registers as they were. Bus accesses are handled by a three-state sequencer. In BUS_IDLE the sequencer waits. The transition "accept" (req high) moves it to BUS_XFER, where a write takes effect and read data is captured. The transition "respond" is unconditional and moves it to BUS_ACK, where ack is high for one cycle. The transition "retire" is also unconditional and returns it to BUS_IDLE.

Top module: `gpio_port`

## Requirements
- R1: A direction bit of 1 sets that pin's pad_oe to 1 and drives pad_out with the matching output-register bit.
- R2: A direction bit of 0 sets that pin's pad_oe to 0 and pad_out to 0, so that an external source can drive the pin.
- R3: For an input pin (direction 0), an output-register bit of 1 sets pad_pu for that pin.
- R4: For an input pin, an output-register bit of 0 clears pad_pu, which leaves the pin fully tri-stated.
- R5: pad_pu is 0 for every pin whose direction bit is 1.
- R6: While sys_rst_n is low, the direction and output registers read as 0x00, so all pad_oe and pad_pu bits are 0.
- R7: Holding pf_rst_n low leaves the direction and output registers unchanged and returns the bus sequencer to idle.
- R8: Address 0 (direction) and address 1 (output) can be written and read back without restriction, and each bit is independent of the others.
- R9: Address 2 returns the pad_in levels after two synchronizing flops, and a write to it changes no register. Address 3 reads 0x00 and a write to it has no effect.
- R10: When req is sampled high in BUS_IDLE, ack is high for exactly one cycle, two clocks later, with rdata valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| sys_rst_n | input | 1 | Active-low system reset; clears all state |
| pf_rst_n | input | 1 | Active-low power-fail reset; registers retained |
| req | input | 1 | Bus request, sampled in idle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 2 | Register address (0 dir, 1 out, 2 in, 3 reserved) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while ack is high |
| ack | output | 1 | One-cycle access completion |
| pad_in | input | 8 | Sampled pin levels |
| pad_out | output | 8 | Per-pin drive value |
| pad_oe | output | 8 | Per-pin output enable |
| pad_pu | output | 8 | Per-pin weak-pullup enable |

## Verification
The bench applies mixed direction and output patterns. It checks that a pin configured as an output never has its pullup enabled, and that an input pin with output bit 0 floats rather than pulling high. A design that mixed up the role of the output bit would show a pulled-up pin where a floating one was expected, or the reverse. It also asserts the power-fail reset partway through and then reads back both registers: a design that cleared them on that reset would return 0x00. It further writes to the input and reserved addresses, where a bad address decode would corrupt the direction or output register. Finally it samples ack on each side of the transfer, which exposes a sequencer that is off by one cycle or holds ack for too long.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    typedef enum logic [1:0] {
        BUS_IDLE = 2'd0,
        BUS_XFER = 2'd1,
        BUS_ACK  = 2'd2
    } bus_state_t;

    localparam logic [1:0] ADR_DIR = 2'd0;
    localparam logic [1:0] ADR_OUT = 2'd1;
    localparam logic [1:0] ADR_IN  = 2'd2;
endpackage

// File: rtl/gpio_bus_fsm.sv
module gpio_bus_fsm
    import gpio_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [WIDTH-1:0]  rd_dir,
    input  logic [WIDTH-1:0]  rd_out,
    input  logic [WIDTH-1:0]  rd_in,
    output logic              wr_dir,
    output logic              wr_out,
    output logic [WIDTH-1:0]  wr_data,
    output logic              ack,
    output logic [WIDTH-1:0]  rdata
);
    bus_state_t        state_q, state_d;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WIDTH-1:0]  wdata_q;
    logic [WIDTH-1:0]  sel_data;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (req) state_d = BUS_XFER;
            BUS_XFER: state_d = BUS_ACK;
            BUS_ACK:  state_d = BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == BUS_IDLE && req) begin
                we_q    <= we;
                addr_q  <= addr;
                wdata_q <= wdata;
            end
            if (state_q == BUS_XFER) rdata <= sel_data;
        end
    end

    always_comb begin
        unique case (addr_q)
            ADR_DIR: sel_data = rd_dir;
            ADR_OUT: sel_data = rd_out;
            ADR_IN:  sel_data = rd_in;
            default: sel_data = '0;
        endcase
    end

    always_comb begin
        wr_dir  = 1'b0;
        wr_out  = 1'b0;
        ack     = 1'b0;
        wr_data = wdata_q;
        unique case (state_q)
            BUS_IDLE: ;
            BUS_XFER: begin
                wr_dir = we_q && (addr_q == ADR_DIR);
                wr_out = we_q && (addr_q == ADR_OUT);
            end
            BUS_ACK:  ack = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             sys_rst_n,
    input  logic             wr_dir,
    input  logic             wr_out,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] out_q
);
    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            dir_q <= '0;
            out_q <= '0;
        end else begin
            if (wr_dir) dir_q <= wr_data;
            if (wr_out) out_q <= wr_data;
        end
    end
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] out_q,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_pu
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        assign pad_oe[i]  = dir_q[i];
        assign pad_out[i] = dir_q[i] & out_q[i];
        assign pad_pu[i]  = ~dir_q[i] & out_q[i];
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else if (s == 0) stage_q[s] <= d;
            else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
    parameter int WIDTH       = 8,
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              sys_rst_n,
    input  logic              pf_rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  rdata,
    output logic              ack,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_pu
);
    logic             bus_rst_n;
    logic             wr_dir, wr_out;
    logic [WIDTH-1:0] wr_data, dir_q, out_q, in_sync;

    assign bus_rst_n = sys_rst_n & pf_rst_n;

    gpio_bus_fsm #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_bus (
        .clk(clk), .rst_n(bus_rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .rd_dir(dir_q), .rd_out(out_q), .rd_in(in_sync),
        .wr_dir(wr_dir), .wr_out(wr_out), .wr_data(wr_data),
        .ack(ack), .rdata(rdata)
    );

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .sys_rst_n(sys_rst_n), .wr_dir(wr_dir), .wr_out(wr_out),
        .wr_data(wr_data), .dir_q(dir_q), .out_q(out_q)
    );

    gpio_pin_ctrl #(.WIDTH(WIDTH)) u_pins (
        .dir_q(dir_q), .out_q(out_q),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(bus_rst_n), .d(pad_in), .q(in_sync)
    );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             sys_rst_n,
    input logic             pf_rst_n,
    input logic             ack,
    input logic [WIDTH-1:0] pad_out,
    input logic [WIDTH-1:0] pad_oe,
    input logic [WIDTH-1:0] pad_pu
);
    // R5
    pu_off_when_driving_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (pad_pu & pad_oe) == '0);

    // R2
    no_drive_when_input_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (pad_out & ~pad_oe) == '0);

    // R6
    reset_clears_pins_chk: assert property (@(posedge clk)
        !sys_rst_n |=> (pad_oe == '0 && pad_pu == '0));

    // R7
    pf_retains_oe_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
        !pf_rst_n |=> $stable(pad_oe) && $stable(pad_pu));

    // R10
    ack_single_cycle_chk: assert property (@(posedge clk) disable iff (!sys_rst_n || !pf_rst_n)
        ack |=> !ack);
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .sys_rst_n(sys_rst_n), .pf_rst_n(pf_rst_n), .ack(ack),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
);

// File: tb/gpio_port_tb.sv
`timescale 1ns/1ps
module gpio_port_tb;
    localparam int W = 8;
    localparam int NV = 6;

    logic clk = 1'b0;
    logic sys_rst_n = 1'b0, pf_rst_n = 1'b1;
    logic req = 1'b0, we = 1'b0;
    logic [1:0] addr = '0;
    logic [W-1:0] wdata = '0, rdata;
    logic ack;
    logic [W-1:0] pad_in, pad_out, pad_oe, pad_pu;
    logic [W-1:0] ext_en = '0, ext_val = '0;
    int n_run = 0, n_fail = 0;
    logic [W-1:0] rd;

    always #2.5 clk = ~clk;

    gpio_port u_dut (
        .clk(clk), .sys_rst_n(sys_rst_n), .pf_rst_n(pf_rst_n), .req(req), .we(we),
        .addr(addr), .wdata(wdata), .rdata(rdata), .ack(ack), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    // Pad net resolution: driver, then external source, then pullup, else floats low.
    always_comb begin
        for (int i = 0; i < W; i++)
            pad_in[i] = pad_oe[i] ? pad_out[i] : ext_en[i] ? ext_val[i] : pad_pu[i];
    end

    localparam logic [W-1:0] V_DIR [NV] = '{8'h00, 8'hFF, 8'h00, 8'hF0, 8'h55, 8'h81};
    localparam logic [W-1:0] V_OUT [NV] = '{8'h00, 8'h3C, 8'hFF, 8'hAA, 8'h0F, 8'h7E};
    localparam logic [W-1:0] V_EN  [NV] = '{8'hFF, 8'h00, 8'h0F, 8'h0F, 8'hAA, 8'h7E};
    localparam logic [W-1:0] V_VAL [NV] = '{8'hA5, 8'h00, 8'h05, 8'h09, 8'h88, 8'h00};
    localparam logic [W-1:0] V_PU  [NV] = '{8'h00, 8'h00, 8'hFF, 8'h0A, 8'h0A, 8'h7E};

    function automatic logic [W-1:0] pin_level(input logic [W-1:0] d, o, e, v);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[i] = d[i] ? o[i] : e[i] ? v[i] : o[i];
        return r;
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic bus(input logic w, input logic [1:0] a, input logic [W-1:0] d,
                       output logic [W-1:0] r);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0;
        check("R10 ack low in transfer", {7'd0, ack}, 8'd0);
        @(negedge clk);
        check("R10 ack high", {7'd0, ack}, 8'd1);
        r = rdata;
        @(negedge clk);
        check("R10 ack single cycle", {7'd0, ack}, 8'd0);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        check("R6 oe in reset", pad_oe, 8'h00);
        check("R6 pu in reset", pad_pu, 8'h00);
        sys_rst_n = 1'b1;
        bus(1'b0, 2'd0, 8'h00, rd); check("R6 dir after reset", rd, 8'h00);
        bus(1'b0, 2'd1, 8'h00, rd); check("R6 out after reset", rd, 8'h00);

        for (int k = 0; k < NV; k++) begin
            bus(1'b1, 2'd0, V_DIR[k], rd);
            bus(1'b1, 2'd1, V_OUT[k], rd);
            ext_en = V_EN[k]; ext_val = V_VAL[k];
            repeat (3) @(negedge clk);
            check("R1 R2 oe", pad_oe, V_DIR[k]);
            check("R1 R2 drive", pad_out, V_DIR[k] & V_OUT[k]);
            check("R3 R4 R5 pullup", pad_pu, V_PU[k]);
            bus(1'b0, 2'd2, 8'h00, rd);
            check("R9 input sync", rd, pin_level(V_DIR[k], V_OUT[k], V_EN[k], V_VAL[k]));
            bus(1'b0, 2'd0, 8'h00, rd); check("R8 dir readback", rd, V_DIR[k]);
            bus(1'b0, 2'd1, 8'h00, rd); check("R8 out readback", rd, V_OUT[k]);
        end

        bus(1'b1, 2'd0, 8'hC3, rd);
        bus(1'b1, 2'd1, 8'h5A, rd);
        bus(1'b1, 2'd2, 8'hFF, rd);
        bus(1'b1, 2'd3, 8'hFF, rd);
        bus(1'b0, 2'd0, 8'h00, rd); check("R9 write to in/reserved leaves dir", rd, 8'hC3);
        bus(1'b0, 2'd1, 8'h00, rd); check("R9 write to in/reserved leaves out", rd, 8'h5A);
        bus(1'b0, 2'd3, 8'h00, rd); check("R9 reserved reads zero", rd, 8'h00);

        @(negedge clk); pf_rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 oe kept in power-fail", pad_oe, 8'hC3);
        pf_rst_n = 1'b1;
        bus(1'b0, 2'd0, 8'h00, rd); check("R7 dir retained", rd, 8'hC3);
        bus(1'b0, 2'd1, 8'h00, rd); check("R7 out retained", rd, 8'h5A);

        @(negedge clk); sys_rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R6 oe cleared", pad_oe, 8'h00);
        sys_rst_n = 1'b1;
        bus(1'b0, 2'd0, 8'h00, rd); check("R6 dir cleared", rd, 8'h00);
        bus(1'b0, 2'd1, 8'h00, rd); check("R6 out cleared", rd, 8'h00);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule